// File: doc/BRIEF.md
# Compressed-Row Sparse Matrix-Vector Engine

This block multiplies a sparse integer matrix by a dense integer vector, y = A·x. The matrix arrives in compressed-row form through three read ports. A row-offset table gives, for each row, where that row's entries begin and end. A column table and a coefficient table share one address. A fourth read port reaches the dense vector memory. All four ports are combinational: the address the block drives in a cycle returns its data in the same cycle. The arrays themselves sit outside the block, and loading them is not part of this block's job.

After a one-cycle `start`, the engine reads the first row offset. It then processes the rows in aligned windows of `BLK` rows. At the start of each window it copies the vector entries whose indices fall inside that window into a small local cache. For each row it reads the closing offset. It then consumes one stored entry per cycle, taking the vector operand from the cache when the column lies inside the current window and from the vector memory otherwise. Each finished row is presented once on the result port, together with its row index. Two counters report how many operands came from the cache and how many did not.

Top module: `spmv_csr_engine`

## Requirements
- R1: For each row r below `num_rows`, the result equals the sum over positions p from offset[r] up to, but not including, offset[r+1] of coefficient[p] × x[column[p]].
- R2: A row whose two offsets are equal produces a result of 0 and still gets its own result beat.
- R3: Exactly `num_rows` results appear, each for one cycle with `y_valid` high and `y_row` carrying its row index, in ascending order from row 0. With `num_rows` = 0, no result appears.
- R4: Products and sums are `DATA_W`-bit two's complement values that wrap on overflow; for example 0x7FFF + 0x0001 gives 0x8000.
- R5: The window of row r starts at r rounded down to a multiple of `BLK` and ends at the lesser of that start plus `BLK` and `num_rows`. A column index in [start, end) counts as a cache hit. Any other column index counts as a miss and is read from the vector memory.
- R6: `done` is high for exactly one cycle. That cycle is cycle number 2 + 2·`num_rows` + nnz after the clock edge that samples `start`, where nnz is offset[`num_rows`]. After that cycle the block is idle.
- R7: While `busy` is high, `start` is ignored. The run's results, counts and timing are the same as if no second `start` had come.
- R8: After reset, `busy`, `done` and `y_valid` are low and both counters read zero.
- R9: Both counters clear when a run starts. At the end of the run, hits plus misses equal the run's nonzero count, and neither counter moves while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| num_rows | input | IDX_W+1 | Row count for the run, at most 2^IDX_W |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rp_addr | output | IDX_W+1 | Row-offset table address |
| rp_data | input | NZ_W | Row-offset table data |
| nz_addr | output | NZ_W | Shared address of column and coefficient tables |
| nz_val | input | DATA_W | Coefficient at `nz_addr` |
| nz_col | input | IDX_W | Column index at `nz_addr` |
| x_addr | output | IDX_W | Vector memory address |
| x_data | input | DATA_W | Vector memory data |
| y_valid | output | 1 | Result beat valid |
| y_row | output | IDX_W+1 | Row index of the result |
| y_data | output | DATA_W | Row result |
| hit_count | output | CNT_W | Operands taken from the window cache this run |
| miss_count | output | CNT_W | Operands taken from the vector memory this run |

## Verification
A wrong row pointer or a stale end offset shows up as a wrong or missing `y_data` at that row's beat, and it moves the `done` pulse by a predictable number of cycles. A wrong window bound or a bad cache fill changes the hit/miss split at the end of the run. It also corrupts the result of the first row that uses the affected column, within that row's beat. An accumulator that is not cleared between rows spoils the very next row, and empty rows show it directly, because their expected result is zero. Sequencing faults around window edges and partial last windows are found by matrices whose row counts are not multiples of the window size.

// File: rtl/spmv_pkg.sv
package spmv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PTR0 = 3'd1,
        ST_FILL = 3'd2,
        ST_HDR  = 3'd3,
        ST_NZ   = 3'd4,
        ST_DONE = 3'd5
    } spmv_state_e;

endpackage

// File: rtl/spmv_window.sv
// Decides whether a column index falls in the cached window and gives its slot.
module spmv_window #(
    parameter int IDX_W  = 5,
    parameter int NR_W   = 6,
    parameter int BLK_LG = 2
) (
    input  logic [IDX_W-1:0]  col,
    input  logic [NR_W-1:0]   base,
    input  logic [BLK_LG:0]   len,
    output logic              hit,
    output logic [BLK_LG-1:0] slot
);
    logic [NR_W:0] col_x, lo_x, hi_x;

    always_comb begin
        col_x = (NR_W+1)'(col);
        lo_x  = (NR_W+1)'(base);
        hi_x  = lo_x + (NR_W+1)'(len);
        hit   = (col_x >= lo_x) && (col_x < hi_x);
        // windows are aligned to BLK, so the low bits index the slot
        slot  = col[BLK_LG-1:0];
    end
endmodule

// File: rtl/spmv_xcache.sv
// Small register cache holding the vector entries of one row window.
module spmv_xcache #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_slot,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_slot,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == AW'(g))) begin
                ent_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = ent_q[rd_slot];
endmodule

// File: rtl/spmv_mac.sv
// Wrapping multiply-accumulate; the low W bits of a product do not depend on signedness.
module spmv_mac #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] prod_lo;

    always_comb begin
        prod_lo = W'(a * b);
        sum     = acc + prod_lo;
    end
endmodule

// File: rtl/spmv_csr_engine.sv
module spmv_csr_engine
    import spmv_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5,
    parameter int NZ_W   = 8,
    parameter int BLK    = 4,
    parameter int CNT_W  = 16,
    localparam int NR_W   = IDX_W + 1,
    localparam int BLK_LG = $clog2(BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NR_W-1:0]   num_rows,
    output logic              busy,
    output logic              done,
    output logic [NR_W-1:0]   rp_addr,
    input  logic [NZ_W-1:0]   rp_data,
    output logic [NZ_W-1:0]   nz_addr,
    input  logic [DATA_W-1:0] nz_val,
    input  logic [IDX_W-1:0]  nz_col,
    output logic [IDX_W-1:0]  x_addr,
    input  logic [DATA_W-1:0] x_data,
    output logic              y_valid,
    output logic [NR_W-1:0]   y_row,
    output logic [DATA_W-1:0] y_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    typedef struct packed {
        spmv_state_e       st;
        logic [NR_W-1:0]   nrows;
        logic [NR_W-1:0]   row;
        logic [NR_W-1:0]   wbase;
        logic [BLK_LG:0]   wlen;
        logic [BLK_LG-1:0] fidx;
        logic [NZ_W-1:0]   ptr;
        logic [NZ_W-1:0]   pend;
        logic [DATA_W-1:0] acc;
        logic              yv;
        logic [NR_W-1:0]   yrow;
        logic [DATA_W-1:0] ydat;
        logic [CNT_W-1:0]  hits;
        logic [CNT_W-1:0]  misses;
    } regs_t;

    regs_t r_q, r_d;

    function automatic logic [BLK_LG:0] win_len(input logic [NR_W-1:0] n,
                                                input logic [NR_W-1:0] b);
        logic [NR_W-1:0] rem;
        rem = n - b;
        if (rem >= NR_W'(BLK)) return (BLK_LG+1)'(BLK);
        return rem[BLK_LG:0];
    endfunction

    // window lookup, cache and arithmetic
    logic              win_hit;
    logic [BLK_LG-1:0] win_slot;
    logic [DATA_W-1:0] cache_data;
    logic [DATA_W-1:0] x_oper;
    logic [DATA_W-1:0] mac_sum;
    logic              fill_en;

    spmv_window #(.IDX_W(IDX_W), .NR_W(NR_W), .BLK_LG(BLK_LG)) win_i (
        .col  (nz_col),
        .base (r_q.wbase),
        .len  (r_q.wlen),
        .hit  (win_hit),
        .slot (win_slot)
    );

    assign fill_en = (r_q.st == ST_FILL);

    spmv_xcache #(.W(DATA_W), .DEPTH(BLK)) cache_i (
        .clk     (clk),
        .wr_en   (fill_en),
        .wr_slot (r_q.fidx),
        .wr_data (x_data),
        .rd_slot (win_slot),
        .rd_data (cache_data)
    );

    assign x_oper = win_hit ? cache_data : x_data;

    spmv_mac #(.W(DATA_W)) mac_i (
        .acc (r_q.acc),
        .a   (nz_val),
        .b   (x_oper),
        .sum (mac_sum)
    );

    // memory addresses
    always_comb begin
        rp_addr = (r_q.st == ST_PTR0) ? '0 : r_q.row + NR_W'(1);
        nz_addr = r_q.ptr;
        x_addr  = fill_en ? IDX_W'(r_q.wbase) + IDX_W'(r_q.fidx) : nz_col;
    end

    // next-state computation
    logic              row_done;
    logic [DATA_W-1:0] row_val;
    logic [NR_W-1:0]   row_nx;

    always_comb begin
        r_d      = r_q;
        r_d.yv   = 1'b0;
        row_done = 1'b0;
        row_val  = '0;
        row_nx   = r_q.row + NR_W'(1);

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_PTR0;
                    r_d.nrows  = num_rows;
                    r_d.row    = '0;
                    r_d.wbase  = '0;
                    r_d.hits   = '0;
                    r_d.misses = '0;
                end
            end
            ST_PTR0: begin
                r_d.ptr = rp_data;
                if (r_q.nrows == '0) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.st   = ST_FILL;
                    r_d.fidx = '0;
                    r_d.wlen = win_len(r_q.nrows, '0);
                end
            end
            ST_FILL: begin
                r_d.fidx = r_q.fidx + BLK_LG'(1);
                if ((BLK_LG+1)'(r_q.fidx) == r_q.wlen - (BLK_LG+1)'(1)) begin
                    r_d.st = ST_HDR;
                end
            end
            ST_HDR: begin
                r_d.pend = rp_data;
                r_d.acc  = '0;
                if (rp_data == r_q.ptr) begin
                    row_done = 1'b1;
                    row_val  = '0;
                end else begin
                    r_d.st = ST_NZ;
                end
            end
            ST_NZ: begin
                r_d.ptr = r_q.ptr + NZ_W'(1);
                r_d.acc = mac_sum;
                if (win_hit) r_d.hits   = r_q.hits + CNT_W'(1);
                else         r_d.misses = r_q.misses + CNT_W'(1);
                if (r_q.ptr + NZ_W'(1) == r_q.pend) begin
                    row_done = 1'b1;
                    row_val  = mac_sum;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        if (row_done) begin
            r_d.yv   = 1'b1;
            r_d.yrow = r_q.row;
            r_d.ydat = row_val;
            r_d.row  = row_nx;
            if (row_nx == r_q.nrows) begin
                r_d.st = ST_DONE;
            end else if (row_nx[BLK_LG-1:0] == '0) begin
                r_d.st    = ST_FILL;
                r_d.wbase = row_nx;
                r_d.fidx  = '0;
                r_d.wlen  = win_len(r_q.nrows, row_nx);
            end else begin
                r_d.st = ST_HDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = (r_q.st == ST_DONE);
    assign y_valid    = r_q.yv;
    assign y_row      = r_q.yrow;
    assign y_data     = r_q.ydat;
    assign hit_count  = r_q.hits;
    assign miss_count = r_q.misses;

endmodule

// File: rtl/spmv_csr_engine_chk.sv
module spmv_csr_engine_chk #(
    parameter int NR_W  = 6,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             y_valid,
    input logic [NR_W-1:0]  y_row,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    logic            seen_q;
    logic [NR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (y_valid) begin
            seen_q <= 1'b1;
            last_q <= y_row;
        end
    end

    // R3: results only during a run
    a_r3_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> busy);

    // R3: first result is row 0, later ones step by one
    a_r3_rows_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && seen_q) |-> (y_row == last_q + NR_W'(1)));

    a_r3_first_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && !seen_q) |-> (y_row == '0));

    // R6: done is a single pulse that ends the run
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7: a run cannot end other than through done
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9: one operand per cycle, never both counters at once
    a_r9_one_count: assert property (@(posedge clk) disable iff (!rst_n)
        !((hit_count == $past(hit_count) + CNT_W'(1)) &&
          (miss_count == $past(miss_count) + CNT_W'(1))));

    // R9: counters frozen while idle
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(hit_count) && $stable(miss_count)));

endmodule

bind spmv_csr_engine spmv_csr_engine_chk #(.NR_W(NR_W), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .y_valid    (y_valid),
    .y_row      (y_row),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/spmv_csr_engine_tb_top.sv
module spmv_csr_engine_tb_top;
    localparam int DW   = 16;
    localparam int IW   = 5;
    localparam int NW   = 8;
    localparam int BLK  = 4;
    localparam int CW   = 16;
    localparam int NRW  = IW + 1;
    localparam int NCOL = 1 << IW;

    // stimulus table: rows, max entries per row, seed
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{16, 3, 11}, '{7, 2, 5}, '{32, 5, 77},
        '{5, 0, 3},   '{1, 4, 9}, '{13, 1, 21}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NRW-1:0] num_rows = '0;
    logic busy, done, y_valid;
    logic [NRW-1:0] rp_addr, y_row;
    logic [NW-1:0]  rp_data, nz_addr;
    logic [DW-1:0]  nz_val, x_data, y_data;
    logic [IW-1:0]  nz_col, x_addr;
    logic [CW-1:0]  hit_count, miss_count;

    logic [NW-1:0] rp_mem  [64];
    logic [DW-1:0] val_mem [256];
    logic [IW-1:0] col_mem [256];
    logic [DW-1:0] x_mem   [NCOL];

    assign rp_data = rp_mem[rp_addr];
    assign nz_val  = val_mem[nz_addr];
    assign nz_col  = col_mem[nz_addr];
    assign x_data  = x_mem[x_addr];

    always #5 clk = ~clk;

    spmv_csr_engine #(.DATA_W(DW), .IDX_W(IW), .NZ_W(NW), .BLK(BLK), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .num_rows(num_rows),
        .busy(busy), .done(done), .rp_addr(rp_addr), .rp_data(rp_data),
        .nz_addr(nz_addr), .nz_val(nz_val), .nz_col(nz_col),
        .x_addr(x_addr), .x_data(x_data), .y_valid(y_valid), .y_row(y_row),
        .y_data(y_data), .hit_count(hit_count), .miss_count(miss_count)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // result monitor
    logic [DW-1:0] got [64];
    int  got_n = 0;
    bit  order_ok = 1'b1;
    always @(negedge clk) begin
        if (y_valid) begin
            if (int'(y_row) != got_n) order_ok = 1'b0;
            got[y_row] = y_data;
            got_n++;
        end
    end

    // fill memories from a seed
    task automatic gen(input int n, input int dens, input int seed);
        int unsigned s = seed;
        int pos = 0;
        for (int i = 0; i < NCOL; i++) begin
            s = s * 1103515245 + 12345;
            x_mem[i] = DW'(s >> 9);
        end
        rp_mem[0] = '0;
        for (int r = 0; r < n; r++) begin
            int k;
            s = s * 1103515245 + 12345;
            k = int'((s >> 16) % (dens + 1));
            for (int j = 0; j < k; j++) begin
                s = s * 1103515245 + 12345;
                col_mem[pos] = IW'((s >> 11) % NCOL);
                s = s * 1103515245 + 12345;
                val_mem[pos] = DW'(s >> 13);
                pos++;
            end
            rp_mem[r+1] = NW'(pos);
        end
    endtask

    // run one job and check it against a model built from R1..R6, R9
    task automatic run_case(input int n, input bit poke, input string tag);
        logic [DW-1:0] exp_y [64];
        int ehit = 0, emiss = 0, nnz, cnt;
        for (int r = 0; r < n; r++) begin
            int base = (r / BLK) * BLK;
            int wend = (base + BLK < n) ? base + BLK : n;
            exp_y[r] = '0;
            for (int p = int'(rp_mem[r]); p < int'(rp_mem[r+1]); p++) begin
                int c = int'(col_mem[p]);
                exp_y[r] = exp_y[r] + DW'(val_mem[p] * x_mem[c]);
                if (c >= base && c < wend) ehit++;
                else emiss++;
            end
        end
        nnz = int'(rp_mem[n]);
        got_n = 0;
        order_ok = 1'b1;
        num_rows = NRW'(n);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 5000) begin
            if (poke && cnt == 3) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        @(negedge clk);
        for (int r = 0; r < n; r++)
            chk(got[r] === exp_y[r], $sformatf("R1 %s row %0d", tag, r), got[r], exp_y[r]);
        chk(got_n == n, {"R3 result count ", tag}, got_n, n);
        chk(order_ok, {"R3 ascending rows ", tag}, order_ok, 1);
        chk(int'(hit_count) == ehit, {"R5 hits ", tag}, hit_count, ehit);
        chk(int'(miss_count) == emiss, {"R5 misses ", tag}, miss_count, emiss);
        chk(int'(hit_count) + int'(miss_count) == nnz, {"R9 hit+miss ", tag},
            hit_count + miss_count, nnz);
        chk(cnt == 2 + 2 * n + nnz, {"R6 done cycle ", tag}, cnt, 2 + 2 * n + nnz);
        chk(!busy, {"R6 idle after done ", tag}, busy, 0);
        if (poke) chk(cnt == 2 + 2 * n + nnz, {"R7 restart ignored ", tag}, cnt, 2 + 2 * n + nnz);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(!busy && !done && !y_valid, "R8 control low", {busy, done, y_valid}, 0);
        chk(hit_count == '0 && miss_count == '0, "R8 counters zero",
            {hit_count, miss_count}, 0);

        // table-driven random matrices
        for (int v = 0; v < NVEC; v++) begin
            gen(VEC[v][0], VEC[v][1], VEC[v][2]);
            run_case(VEC[v][0], 1'b0, $sformatf("vec%0d", v));
        end

        // handmade: empty row, one out-of-window column
        for (int i = 0; i < NCOL; i++) x_mem[i] = DW'(i + 1);
        rp_mem[0] = 8'd0; rp_mem[1] = 8'd2; rp_mem[2] = 8'd2; rp_mem[3] = 8'd4; rp_mem[4] = 8'd5;
        col_mem[0] = 5'd1; val_mem[0] = 16'd2;
        col_mem[1] = 5'd3; val_mem[1] = 16'd5;
        col_mem[2] = 5'd0; val_mem[2] = 16'hFFFF;
        col_mem[3] = 5'd5; val_mem[3] = 16'd3;
        col_mem[4] = 5'd2; val_mem[4] = 16'd7;
        run_case(4, 1'b0, "hand");
        chk(got[0] == 16'd24, "R1 hand row0", got[0], 24);
        chk(got[1] == 16'd0, "R2 empty row", got[1], 0);
        chk(got[2] == 16'd17, "R1 hand row2 signed", got[2], 17);
        chk(hit_count == 16'd4 && miss_count == 16'd1, "R5 hand split",
            {hit_count, miss_count}, {16'd4, 16'd1});

        // R4 wrap
        x_mem[1] = 16'd4; x_mem[2] = 16'd1; x_mem[3] = 16'd1;
        rp_mem[0] = 8'd0; rp_mem[1] = 8'd2; rp_mem[2] = 8'd4;
        col_mem[0] = 5'd1; val_mem[0] = 16'h4000;
        col_mem[1] = 5'd2; val_mem[1] = 16'h7FFF;
        col_mem[2] = 5'd3; val_mem[2] = 16'h7FFF;
        col_mem[3] = 5'd2; val_mem[3] = 16'h0001;
        run_case(2, 1'b0, "wrap");
        chk(got[0] == 16'h7FFF, "R4 product wrap", got[0], 16'h7FFF);
        chk(got[1] == 16'h8000, "R4 sum wrap", got[1], 16'h8000);

        // zero rows: no result, done soon
        rp_mem[0] = '0;
        run_case(0, 1'b0, "zero");

        // R7 start while busy, with a partial last window
        gen(10, 3, 55);
        run_case(10, 1'b1, "poke");

        // R9 counters cleared on a new run
        gen(6, 0, 8);
        run_case(6, 1'b0, "clear");
        chk(hit_count == '0 && miss_count == '0, "R9 cleared at start",
            {hit_count, miss_count}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule